// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block is an always-on controller that keeps the operating mode of a small processor system: Run (full PLL clock), Idle, Slow and Off. It drives four controls toward the clocking and power logic: an enable for the CPU core clock gate, a select between the PLL and the crystal as clock source, a request that puts external memory into self-refresh, and an enable for the switchable core supply. Software requests a mode by writing a 2-bit code. The block then returns the system to Run when a wake source that belongs to the current mode fires.

Each low-power mode has its own wake set. Idle stops only the core clock and wakes on any pending interrupt. Slow runs everything from the crystal and has no hardware wake, so only software can end it. Off puts memory into self-refresh, holds core reset and drops the core supply. In Off only the external wake lines, the RTC alarm and a low battery-fault input can wake the system. When Off ends, the supply comes back first and a programmable wait passes before reset and self-refresh are released. A sticky register records which sources ended a low-power mode.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the block is in Run: cpu_clk_en=1, clk_src_xtal=0, mem_sr_req=0, pwr_en=1, core_rst_n=1, mode_now=00, wake_cause=0.
- R2: Mode codes are 00 Run, 01 Idle, 10 Slow, 11 Off. A write of 01 in Run gives cpu_clk_en=0 with clk_src_xtal=0, pwr_en=1 and mode_now=01 one cycle later. Mode writes made while in Idle are ignored.
- R3: In Idle, any set bit of irq_pend returns the block to Run (cpu_clk_en=1, mode_now=00) one cycle later and sets wake_cause bit 0.
- R4: A write of 10 in Run gives mode_now=10 and clock gated with PLL source after 1 cycle, gated with crystal source after 2 cycles, and clock enabled on the crystal after 3 cycles.
- R5: In Slow, irq_pend, ext_irq, rtc_alarm, batt_fault_n and writes other than 00 have no effect and record no wake cause. A write of 00 gives: gated on the crystal, then gated on the PLL, then Run with the clock enabled, one cycle apart.
- R6: clk_src_xtal changes only on an edge where cpu_clk_en is 0 both before and after that edge.
- R7: A write of 11 in Run gives mem_sr_req=1, core_rst_n=0, cpu_clk_en=0 and mode_now=11 after 1 cycle while pwr_en is still 1. pwr_en falls after 2 cycles.
- R8: In Off the only wake sources are any ext_irq line, rtc_alarm=1 and batt_fault_n=0. irq_pend and mode writes are ignored. Wake cause bits: 1 external line, 2 RTC alarm, 3 battery fault.
- R9: An Off wake raises pwr_en on the next edge. core_rst_n and mem_sr_req stay asserted for wait_cycles+1 cycles with pwr_en high, and then the block returns to Run.
- R10: wake_cause bits stay set until cause_clr. A cause_clr removes the old bits, and bits recorded on the same edge are kept.
- R11: Whenever pwr_en is 0, mem_sr_req=1, core_rst_n=0 and cpu_clk_en=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_we | input | 1 | Mode request write strobe |
| req_mode | input | 2 | Requested mode code |
| cause_clr | input | 1 | Software clear of the wake-cause register |
| wait_cycles | input | 8 | Power-up wait after an Off wake, in cycles |
| irq_pend | input | 32 | Pending interrupt vector (Idle wake) |
| ext_irq | input | 16 | External wake lines |
| rtc_alarm | input | 1 | RTC alarm |
| batt_fault_n | input | 1 | Active-low battery fault |
| cpu_clk_en | output | 1 | CPU core clock-gate enable |
| clk_src_xtal | output | 1 | Clock source select: 1 crystal, 0 PLL |
| mem_sr_req | output | 1 | Memory self-refresh request |
| pwr_en | output | 1 | Core and PLL supply enable |
| core_rst_n | output | 1 | Active-low core reset |
| mode_now | output | 2 | Current mode code |
| wake_cause | output | 4 | Sticky wake-cause bits |

## Verification
The assertions check the following on every cycle: the clock source never switches while the core clock runs, the supply never drops unless self-refresh is already on, the Off state always holds reset and self-refresh, reset is released only after the supply is up, Slow and Off hold against sources outside their wake sets, and cause bits are never lost without a clear. The directed scenarios show the cycle-exact entry and exit sequences of Slow and Off, the length of the power-up wait for a nonzero and a zero setting, and which cause bits build up across several wakes. They also show that a clear and a new wake on the same edge keep only the new bits.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'b00,
    MODE_IDLE = 2'b01,
    MODE_SLOW = 2'b10,
    MODE_OFF  = 2'b11
  } mode_e;

  typedef enum logic [3:0] {
    ST_RUN,
    ST_IDLE,
    ST_SLOW_GATE,
    ST_SLOW_SW,
    ST_SLOW,
    ST_EXIT_GATE,
    ST_EXIT_SW,
    ST_OFF_SR,
    ST_OFF,
    ST_OFF_WAIT
  } state_e;

  localparam int CAUSE_W    = 4;
  localparam int CAUSE_IRQ  = 0;
  localparam int CAUSE_EXT  = 1;
  localparam int CAUSE_RTC  = 2;
  localparam int CAUSE_BATT = 3;

  typedef struct packed {
    logic clk_en;
    logic src_xtal;
    logic sr_req;
    logic pwr_en;
    logic rst_n;
  } ctrl_t;

  // Output decode for each sequencer state
  function automatic ctrl_t ctrl_of(state_e s);
    ctrl_t c;
    c = '{clk_en: 1'b1, src_xtal: 1'b0, sr_req: 1'b0, pwr_en: 1'b1, rst_n: 1'b1};
    case (s)
      ST_IDLE, ST_SLOW_GATE, ST_EXIT_SW: c.clk_en = 1'b0;
      ST_SLOW_SW, ST_EXIT_GATE: begin
        c.clk_en   = 1'b0;
        c.src_xtal = 1'b1;
      end
      ST_SLOW: c.src_xtal = 1'b1;
      ST_OFF_SR, ST_OFF_WAIT: begin
        c.clk_en = 1'b0;
        c.sr_req = 1'b1;
        c.rst_n  = 1'b0;
      end
      ST_OFF: begin
        c.clk_en = 1'b0;
        c.sr_req = 1'b1;
        c.rst_n  = 1'b0;
        c.pwr_en = 1'b0;
      end
      default: ;
    endcase
    return c;
  endfunction

  // Mode code reported for each state
  function automatic mode_e mode_of(state_e s);
    case (s)
      ST_IDLE: return MODE_IDLE;
      ST_SLOW_GATE, ST_SLOW_SW, ST_SLOW, ST_EXIT_GATE, ST_EXIT_SW: return MODE_SLOW;
      ST_OFF_SR, ST_OFF, ST_OFF_WAIT: return MODE_OFF;
      default: return MODE_RUN;
    endcase
  endfunction

endpackage

// File: rtl/pwr_wake_filter.sv
module pwr_wake_filter
  import pwr_mode_pkg::*;
#(
  parameter int N_IRQ = 32,
  parameter int N_EXT = 16
) (
  input  logic               idle_armed,
  input  logic               off_armed,
  input  logic [N_IRQ-1:0]   irq_pend,
  input  logic [N_EXT-1:0]   ext_irq,
  input  logic               rtc_alarm,
  input  logic               batt_fault_n,
  output logic               wake_hit,
  output logic [CAUSE_W-1:0] wake_bits
);

  logic any_irq, any_ext;
  assign any_irq = |irq_pend;
  assign any_ext = |ext_irq;

  always_comb begin
    wake_bits             = '0;
    wake_bits[CAUSE_IRQ]  = idle_armed & any_irq;
    wake_bits[CAUSE_EXT]  = off_armed & any_ext;
    wake_bits[CAUSE_RTC]  = off_armed & rtc_alarm;
    wake_bits[CAUSE_BATT] = off_armed & ~batt_fault_n;
  end

  assign wake_hit = |wake_bits;

endmodule

// File: rtl/pwr_wake_cause.sv
module pwr_wake_cause
  import pwr_mode_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CAUSE_W-1:0] set_bits,
  input  logic               clr,
  output logic [CAUSE_W-1:0] cause
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause <= '0;
    else        cause <= (clr ? '0 : cause) | set_bits;
  end

  // R10: without a clear, no recorded bit is lost
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((cause & $past(cause)) == $past(cause)));

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_we,
  input  logic [1:0]       req_mode,
  input  logic             wake_hit,
  input  logic [CNT_W-1:0] wait_cycles,
  output state_e           state_q,
  output ctrl_t            ctrl_q,
  output mode_e            mode_q
);

  state_e           state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  mode_e            req;
  logic             wait_done;

  assign req       = mode_e'(req_mode);
  assign wait_done = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_RUN:
        if (req_we) begin
          case (req)
            MODE_IDLE: state_d = ST_IDLE;
            MODE_SLOW: state_d = ST_SLOW_GATE;
            MODE_OFF:  state_d = ST_OFF_SR;
            default:   state_d = ST_RUN;
          endcase
        end
      ST_IDLE:      if (wake_hit) state_d = ST_RUN;
      ST_SLOW_GATE: state_d = ST_SLOW_SW;
      ST_SLOW_SW:   state_d = ST_SLOW;
      ST_SLOW:      if (req_we && req == MODE_RUN) state_d = ST_EXIT_GATE;
      ST_EXIT_GATE: state_d = ST_EXIT_SW;
      ST_EXIT_SW:   state_d = ST_RUN;
      ST_OFF_SR:    state_d = ST_OFF;
      ST_OFF:
        if (wake_hit) begin
          state_d = ST_OFF_WAIT;
          cnt_d   = wait_cycles;
        end
      ST_OFF_WAIT:
        if (wait_done) state_d = ST_RUN;
        else           cnt_d   = cnt_q - 1'b1;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
      ctrl_q  <= ctrl_of(ST_RUN);
      mode_q  <= MODE_RUN;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ctrl_q  <= ctrl_of(state_d);
      mode_q  <= mode_of(state_d);
    end
  end

  // R6: the source select moves only while the core clock is gated on both sides
  a_r6_src_when_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q.src_xtal) |-> (!ctrl_q.clk_en && !$past(ctrl_q.clk_en)));

  // R7: supply drops only after self-refresh is already requested
  a_r7_sr_before_pwr_off: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_q.pwr_en) |-> ($past(ctrl_q.sr_req) && !$past(ctrl_q.rst_n)));

  // R11: supply off implies refresh held, reset held and clock gated
  a_r11_off_held: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.pwr_en |-> (ctrl_q.sr_req && !ctrl_q.rst_n && !ctrl_q.clk_en));

  // R9: reset release only follows a cycle with the supply up
  a_r9_pwr_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q.rst_n) |-> $past(ctrl_q.pwr_en));

  // R9: self-refresh ends together with the reset release
  a_r9_sr_with_rst: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_q.sr_req) |-> $rose(ctrl_q.rst_n));

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int N_IRQ = 32,
  parameter int N_EXT = 16,
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_we,
  input  logic [1:0]         req_mode,
  input  logic               cause_clr,
  input  logic [CNT_W-1:0]   wait_cycles,
  input  logic [N_IRQ-1:0]   irq_pend,
  input  logic [N_EXT-1:0]   ext_irq,
  input  logic               rtc_alarm,
  input  logic               batt_fault_n,
  output logic               cpu_clk_en,
  output logic               clk_src_xtal,
  output logic               mem_sr_req,
  output logic               pwr_en,
  output logic               core_rst_n,
  output logic [1:0]         mode_now,
  output logic [CAUSE_W-1:0] wake_cause
);

  state_e               st;
  ctrl_t                ctrl;
  mode_e                mode;
  logic                 idle_armed, off_armed;
  logic                 wake_hit;
  logic [CAUSE_W-1:0]   wake_bits;

  assign idle_armed = (st == ST_IDLE);
  assign off_armed  = (st == ST_OFF);

  pwr_wake_filter #(.N_IRQ(N_IRQ), .N_EXT(N_EXT)) u_filter (
    .idle_armed  (idle_armed),
    .off_armed   (off_armed),
    .irq_pend    (irq_pend),
    .ext_irq     (ext_irq),
    .rtc_alarm   (rtc_alarm),
    .batt_fault_n(batt_fault_n),
    .wake_hit    (wake_hit),
    .wake_bits   (wake_bits)
  );

  pwr_mode_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_we     (req_we),
    .req_mode   (req_mode),
    .wake_hit   (wake_hit),
    .wait_cycles(wait_cycles),
    .state_q    (st),
    .ctrl_q     (ctrl),
    .mode_q     (mode)
  );

  pwr_wake_cause u_cause (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_bits(wake_bits),
    .clr     (cause_clr),
    .cause   (wake_cause)
  );

  assign cpu_clk_en   = ctrl.clk_en;
  assign clk_src_xtal = ctrl.src_xtal;
  assign mem_sr_req   = ctrl.sr_req;
  assign pwr_en       = ctrl.pwr_en;
  assign core_rst_n   = ctrl.rst_n;
  assign mode_now     = mode;

  // R2: an Idle request from Run gates the core clock on the next edge
  a_r2_idle_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && req_we && req_mode == MODE_IDLE) |=>
      (!cpu_clk_en && !clk_src_xtal && pwr_en && mode_now == MODE_IDLE));

  // R3: a pending interrupt ends Idle on the next edge
  a_r3_idle_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && |irq_pend) |=> (cpu_clk_en && mode_now == MODE_RUN));

  // R5: Slow holds against everything but a Run write
  a_r5_slow_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SLOW && !(req_we && req_mode == MODE_RUN)) |=>
      (st == ST_SLOW && cpu_clk_en && clk_src_xtal));

  // R8: Off stays unpowered without one of its own wake sources
  a_r8_off_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OFF && !(|ext_irq) && !rtc_alarm && batt_fault_n) |=> !pwr_en);

endmodule

// File: tb/pwr_mode_seq_tb.sv
module pwr_mode_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_we = 1'b0;
  logic [1:0]  req_mode = 2'b00;
  logic        cause_clr = 1'b0;
  logic [7:0]  wait_cycles = 8'd0;
  logic [31:0] irq_pend = '0;
  logic [15:0] ext_irq = '0;
  logic        rtc_alarm = 1'b0;
  logic        batt_fault_n = 1'b1;
  logic        cpu_clk_en, clk_src_xtal, mem_sr_req, pwr_en, core_rst_n;
  logic [1:0]  mode_now;
  logic [3:0]  wake_cause;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwr_mode_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_we(req_we), .req_mode(req_mode),
    .cause_clr(cause_clr), .wait_cycles(wait_cycles), .irq_pend(irq_pend),
    .ext_irq(ext_irq), .rtc_alarm(rtc_alarm), .batt_fault_n(batt_fault_n),
    .cpu_clk_en(cpu_clk_en), .clk_src_xtal(clk_src_xtal), .mem_sr_req(mem_sr_req),
    .pwr_en(pwr_en), .core_rst_n(core_rst_n), .mode_now(mode_now), .wake_cause(wake_cause)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // packs {clk_en, src_xtal, sr_req, pwr_en, rst_n}
  function automatic logic [4:0] ctl();
    return {cpu_clk_en, clk_src_xtal, mem_sr_req, pwr_en, core_rst_n};
  endfunction

  task automatic write_mode(input logic [1:0] m);
    req_we = 1'b1; req_mode = m;
    tick();
    req_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 controls", ctl(), 5'b10011);
    chk("R1 mode", mode_now, 2'b00);
    chk("R1 cause", wake_cause, 4'b0000);
  endtask

  task automatic t_idle();
    write_mode(2'b01);
    chk("R2 idle controls", ctl(), 5'b00011);
    chk("R2 idle mode", mode_now, 2'b01);
    write_mode(2'b00);
    tick();
    chk("R2 idle ignores write", mode_now, 2'b01);
    irq_pend = 32'h0002_0000;
    tick();
    irq_pend = '0;
    chk("R3 idle wake controls", ctl(), 5'b10011);
    chk("R3 idle wake mode", mode_now, 2'b00);
    chk("R3 idle wake cause", wake_cause, 4'b0001);
  endtask

  task automatic t_slow();
    write_mode(2'b10);
    chk("R4 slow step1", ctl(), 5'b00011);
    chk("R4 slow mode", mode_now, 2'b10);
    tick();
    chk("R4 R6 slow step2", ctl(), 5'b01011);
    tick();
    chk("R4 slow running", ctl(), 5'b11011);
    irq_pend = '1; ext_irq = '1; rtc_alarm = 1'b1; batt_fault_n = 1'b0;
    write_mode(2'b01);
    write_mode(2'b11);
    tick(); tick();
    irq_pend = '0; ext_irq = '0; rtc_alarm = 1'b0; batt_fault_n = 1'b1;
    chk("R5 slow holds mode", mode_now, 2'b10);
    chk("R5 slow holds controls", ctl(), 5'b11011);
    chk("R5 slow no cause", wake_cause, 4'b0001);
    write_mode(2'b00);
    chk("R5 exit step1", ctl(), 5'b01011);
    tick();
    chk("R5 R6 exit step2", ctl(), 5'b00011);
    tick();
    chk("R5 exit run", ctl(), 5'b10011);
    chk("R5 exit mode", mode_now, 2'b00);
  endtask

  task automatic t_off();
    wait_cycles = 8'd5;
    write_mode(2'b11);
    chk("R7 off step1", ctl(), 5'b00110);
    chk("R7 off mode", mode_now, 2'b11);
    tick();
    chk("R7 R11 off step2", ctl(), 5'b00100);
    irq_pend = '1;
    write_mode(2'b00);
    tick(); tick();
    irq_pend = '0;
    chk("R8 off ignores irq and write", ctl(), 5'b00100);
    rtc_alarm = 1'b1;
    tick();
    rtc_alarm = 1'b0;
    chk("R9 supply first", ctl(), 5'b00110);
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R9 wait holds reset", ctl(), 5'b00110);
    end
    tick();
    chk("R9 release", ctl(), 5'b10011);
    chk("R9 mode run", mode_now, 2'b00);
    chk("R8 R10 rtc cause", wake_cause, 4'b0101);
  endtask

  task automatic t_cause();
    cause_clr = 1'b1;
    tick();
    cause_clr = 1'b0;
    chk("R10 clear", wake_cause, 4'b0000);
    wait_cycles = 8'd0;
    write_mode(2'b11);
    tick();
    batt_fault_n = 1'b0;
    tick();
    batt_fault_n = 1'b1;
    chk("R9 zero wait supply", ctl(), 5'b00110);
    tick();
    chk("R9 zero wait release", ctl(), 5'b10011);
    chk("R8 batt cause", wake_cause, 4'b1000);
    write_mode(2'b11);
    tick();
    ext_irq = 16'h8000;
    cause_clr = 1'b1;
    tick();
    ext_irq = '0;
    cause_clr = 1'b0;
    chk("R10 clear with new wake", wake_cause, 4'b0010);
    tick();
    chk("R8 ext wake run", ctl(), 5'b10011);
  endtask

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_idle();
    t_slow();
    t_off();
    t_cause();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule